// File: doc/BRIEF.md
# Loopback Pattern Engine

This block produces a stream of 32-bit test words for a link under loopback and checks the words that come back. The transmit side runs one of six patterns, chosen at run time. Four are maximal-length pseudo-random sequences of order 7, 15, 23 and 31. The fifth is a toggle pattern at half the bit rate. The sixth is a square wave that holds each level for 33 bit times. On request, the transmit side damages exactly one word so that the error path can be exercised.

The receive side first aligns to the incoming stream without any help from the transmit side. For the pseudo-random orders it loads its local shift register from the received bits. For the two clock-like patterns it recovers the phase from a level transition. After alignment it predicts every following word on its own and counts each word that does not match. Words that arrive before alignment are never counted. A run of mismatching words makes the receive side give up alignment and search again.

The test is controlled by three pulses: start, stop and clear. A pulse on clear zeroes both the inserted-error and detected-error counters.

Top module: `loopback_pattern_engine`

## Requirements
- R1: With `pat_sel` 0, 1, 2 or 3, the transmitted bit stream obeys x[t] = x[t-n] xor x[t-k] with (n,k) = (7,6), (15,14), (23,18), (31,28). Bits are taken from each word most significant bit first. The shift register is loaded with all ones at each start, so the stream is never all zeros.
- R2: With `pat_sel` 4, every uncorrupted transmitted word is 32'hAAAAAAAA, so the first bit in time is a one.
- R3: With `pat_sel` 5, the stream begins with a one at start, and every run of equal bits is exactly 33 bits long across word boundaries.
- R4: The clock edge that samples `start` emits no word. From the following edge, one word with `tx_valid` high is emitted per cycle. The edge that samples `stop` ends the stream. `stop` wins over `start` when both are high.
- R5: While a test is running, an `err_insert` pulse inverts bit 0 of the word emitted at that same edge. `ins_count` rises by one at that edge.
- R6: While no test is running, `err_insert` has no effect: `ins_count` holds its value and `tx_valid` stays low.
- R7: After start, with `tx_data` looped back to `rx_data`, `locked` rises within three received words and stays high while the data is clean.
- R8: Received words are never counted while `locked` is low. A received stream of all zeros never brings `locked` high under a pseudo-random pattern.
- R9: While `locked` is high, `det_count` rises by one at the edge that accepts each received word that differs from the predicted word.
- R10: Eight consecutive mismatching words drop `locked` at the edge of the eighth, and the search then starts again. Seven consecutive mismatches leave `locked` high.
- R11: A `clear` pulse sets `ins_count` and `det_count` to zero at the next edge, and it takes priority over any increment.
- R12: Changing `pat_sel` while running restarts the test at the next edge. `locked` drops, no word is emitted on that edge, and the generator reloads its start state for the new pattern.
- R13: After reset, `locked`, `tx_valid`, `ins_count` and `det_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_sel | input | 3 | Pattern code: 0..3 pseudo-random orders 7/15/23/31, 4 toggle, 5 33-bit square wave (6 and 7 behave as order 31) |
| start | input | 1 | Pulse that begins or restarts a test |
| stop | input | 1 | Pulse that ends a test |
| clear | input | 1 | Pulse that zeroes both counters |
| err_insert | input | 1 | Pulse requesting one corrupted transmit word |
| tx_data | output | 32 | Transmit word, most significant bit first in time |
| tx_valid | output | 1 | Transmit word strobe |
| rx_data | input | 32 | Received word |
| rx_valid | input | 1 | Received word strobe |
| locked | output | 1 | Receive side aligned to the pattern |
| ins_count | output | CNT_W | Number of corrupted words sent |
| det_count | output | CNT_W | Number of mismatching words received while locked |

## Verification
Each transmit result appears one edge after its cause. The first valid word follows the edge that samples start, and a corrupted word and its `ins_count` step appear at the very edge that samples `err_insert`. On the receive side, a mismatch is counted at the edge that accepts the word. In loopback that is one edge after the edge that sent the word, so `det_count` trails `ins_count` by exactly one cycle. The bench drives inputs on falling edges and reads each result at the falling edge that follows the rising edge where the result is due. Because of that, the corruption, both counter steps, the loss of lock after the eighth bad word and the drop on a pattern change are each checked in their own cycle and not after a settling delay. Alignment is the one exception: it can take up to three words, so it is checked only after a long run.

// File: rtl/lbk_pkg.sv
`timescale 1ns/1ps
package lbk_pkg;
    localparam int DW        = 32;  // word width
    localparam int SW        = 31;  // shift register width (largest order)
    localparam int LF_HALF   = 33;  // bits per level of the slow pattern
    localparam int LF_PERIOD = 2 * LF_HALF;
    localparam int PH_W      = $clog2(LF_PERIOD);

    localparam logic [2:0] PAT_P7  = 3'd0;
    localparam logic [2:0] PAT_P15 = 3'd1;
    localparam logic [2:0] PAT_P23 = 3'd2;
    localparam logic [2:0] PAT_P31 = 3'd3;
    localparam logic [2:0] PAT_HF  = 3'd4;
    localparam logic [2:0] PAT_LF  = 3'd5;

    localparam logic [DW-1:0] HF_WORD = {(DW/2){2'b10}};

    typedef struct packed {
        logic [DW-1:0] word;
        logic [SW-1:0] state;
    } prbs_out_t;

    typedef struct packed {
        logic            ok;
        logic [PH_W-1:0] ph;   // phase of the word that follows the inspected one
    } lf_lock_t;

    // Step the shift register DW times; each new bit is also the output bit.
    function automatic prbs_out_t prbs_word(input logic [SW-1:0] seed, input logic [2:0] pat);
        prbs_out_t     r;
        logic [SW-1:0] s;
        logic [4:0]    ta;
        logic [4:0]    tb;
        logic          nb;
        case (pat)
            PAT_P7:  begin ta = 5'd6;  tb = 5'd5;  end
            PAT_P15: begin ta = 5'd14; tb = 5'd13; end
            PAT_P23: begin ta = 5'd22; tb = 5'd17; end
            default: begin ta = 5'd30; tb = 5'd27; end
        endcase
        s      = seed;
        r.word = '0;
        for (int i = 0; i < DW; i++) begin
            nb              = s[ta] ^ s[tb];
            r.word[DW-1-i]  = nb;
            s               = {s[SW-2:0], nb};
        end
        r.state = s;
        return r;
    endfunction

    function automatic logic [SW-1:0] prbs_mask(input logic [2:0] pat);
        logic [SW-1:0] m;
        int            n;
        case (pat)
            PAT_P7:  n = 7;
            PAT_P15: n = 15;
            PAT_P23: n = 23;
            default: n = 31;
        endcase
        for (int i = 0; i < SW; i++) m[i] = (i < n);
        return m;
    endfunction

    function automatic logic [DW-1:0] lf_word(input logic [PH_W-1:0] ph);
        logic [DW-1:0] w;
        int            p;
        for (int i = 0; i < DW; i++) begin
            p = int'(ph) + i;
            if (p >= LF_PERIOD) p = p - LF_PERIOD;
            w[DW-1-i] = (p < LF_HALF);
        end
        return w;
    endfunction

    function automatic logic [PH_W-1:0] lf_adv(input logic [PH_W-1:0] ph);
        int p;
        p = int'(ph) + DW;
        if (p >= LF_PERIOD) p = p - LF_PERIOD;
        return PH_W'(p);
    endfunction

    // Find the first level change in a word and derive the phase of the next word.
    function automatic lf_lock_t lf_lock(input logic [DW-1:0] w);
        lf_lock_t r;
        int       p;
        r.ok = 1'b0;
        r.ph = '0;
        for (int i = 1; i < DW; i++) begin
            if (!r.ok && (w[DW-1-i] != w[DW-i])) begin
                r.ok = 1'b1;
                p = (w[DW-1-i] ? 0 : LF_HALF) + LF_PERIOD - i;
                if (p >= LF_PERIOD) p = p - LF_PERIOD;
                p = p + DW;
                if (p >= LF_PERIOD) p = p - LF_PERIOD;
                r.ph = PH_W'(p);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/lbk_count.sv
`timescale 1ns/1ps
module lbk_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/lbk_gen.sv
`timescale 1ns/1ps
module lbk_gen
    import lbk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          emit,
    input  logic          corrupt,
    input  logic [2:0]    pat,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid
);
    typedef struct packed {
        logic [SW-1:0]   st;
        logic [PH_W-1:0] ph;
        logic [DW-1:0]   data;
        logic            valid;
    } gen_t;

    gen_t      gen_d, gen_q;
    prbs_out_t step;
    logic [DW-1:0] word;

    always_comb begin
        step  = prbs_word(gen_q.st, pat);
        gen_d = gen_q;
        gen_d.valid = 1'b0;
        word  = step.word;
        if (restart) begin
            gen_d.st = '1;
            gen_d.ph = '0;
        end else if (emit) begin
            if (pat == PAT_HF) begin
                word = HF_WORD;
            end else if (pat == PAT_LF) begin
                word     = lf_word(gen_q.ph);
                gen_d.ph = lf_adv(gen_q.ph);
            end else begin
                gen_d.st = step.state;
            end
            gen_d.data  = word ^ {{(DW-1){1'b0}}, corrupt};
            gen_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '{st: '1, ph: '0, data: '0, valid: 1'b0};
        else        gen_q <= gen_d;
    end

    assign tx_data  = gen_q.data;
    assign tx_valid = gen_q.valid;
endmodule

// File: rtl/lbk_chk.sv
`timescale 1ns/1ps
module lbk_chk
    import lbk_pkg::*;
#(
    parameter int LOSS_LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          active,
    input  logic [2:0]    pat,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          locked,
    output logic          err_hit
);
    localparam int MW = $clog2(LOSS_LIMIT + 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_LIMIT - 1);

    typedef struct packed {
        logic            sync;
        logic            pred_ok;
        logic [DW-1:0]   pred;
        logic [SW-1:0]   st;
        logic [PH_W-1:0] ph;
        logic [MW-1:0]   miss;
    } chk_t;

    chk_t      chk_d, chk_q;
    prbs_out_t po_seed, po_free;
    lf_lock_t  lk;
    logic [DW-1:0]   s_pred, f_pred;
    logic [SW-1:0]   s_st, f_st;
    logic [PH_W-1:0] s_ph, f_ph;
    logic            s_ok, hit, reseed;

    always_comb begin
        po_seed = prbs_word(rx_data[SW-1:0], pat);
        po_free = prbs_word(chk_q.st, pat);
        lk      = lf_lock(rx_data);
        // candidate built from the received word (alignment)
        s_pred = po_seed.word;
        s_ok   = |(rx_data[SW-1:0] & prbs_mask(pat));
        s_st   = po_seed.state;
        s_ph   = chk_q.ph;
        // candidate built from local state (free running)
        f_pred = po_free.word;
        f_st   = po_free.state;
        f_ph   = chk_q.ph;
        if (pat == PAT_HF) begin
            s_pred = rx_data;
            s_ok   = (rx_data == HF_WORD) || (rx_data == ~HF_WORD);
            s_st   = chk_q.st;
            f_pred = chk_q.pred;
            f_st   = chk_q.st;
        end else if (pat == PAT_LF) begin
            s_pred = lf_word(lk.ph);
            s_ok   = lk.ok;
            s_st   = chk_q.st;
            s_ph   = lf_adv(lk.ph);
            f_pred = lf_word(chk_q.ph);
            f_st   = chk_q.st;
            f_ph   = lf_adv(chk_q.ph);
        end

        hit     = chk_q.pred_ok && (rx_data == chk_q.pred);
        reseed  = 1'b1;
        err_hit = 1'b0;
        chk_d   = chk_q;

        if (restart) begin
            chk_d.sync    = 1'b0;
            chk_d.pred_ok = 1'b0;
            chk_d.miss    = '0;
        end else if (active && rx_valid) begin
            if (chk_q.sync) begin
                reseed = 1'b0;
                if (!hit) begin
                    err_hit = 1'b1;
                    if (chk_q.miss == MISS_LAST) begin
                        chk_d.sync = 1'b0;
                        chk_d.miss = '0;
                        reseed     = 1'b1;
                    end else begin
                        chk_d.miss = chk_q.miss + 1'b1;
                    end
                end else begin
                    chk_d.miss = '0;
                end
            end else if (hit) begin
                chk_d.sync = 1'b1;
                chk_d.miss = '0;
            end

            if (reseed) begin
                chk_d.pred    = s_pred;
                chk_d.pred_ok = s_ok;
                chk_d.st      = s_st;
                chk_d.ph      = s_ph;
            end else begin
                chk_d.pred    = f_pred;
                chk_d.pred_ok = 1'b1;
                chk_d.st      = f_st;
                chk_d.ph      = f_ph;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '{sync: 1'b0, pred_ok: 1'b0, pred: '0, st: '0, ph: '0, miss: '0};
        else        chk_q <= chk_d;
    end

    assign locked = chk_q.sync;
endmodule

// File: rtl/loopback_pattern_engine.sv
`timescale 1ns/1ps
module loopback_pattern_engine
    import lbk_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LOSS_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       pat_sel,
    input  logic             start,
    input  logic             stop,
    input  logic             clear,
    input  logic             err_insert,
    output logic [DW-1:0]    tx_data,
    output logic             tx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_valid,
    output logic             locked,
    output logic [CNT_W-1:0] ins_count,
    output logic [CNT_W-1:0] det_count
);
    typedef struct packed {
        logic       run;
        logic [2:0] pat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic restart, emit, ins_hit, err_hit;
    logic run_q;
    logic [2:0] pat_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.pat = pat_sel;
        restart   = (start || (ctl_q.run && (pat_sel != ctl_q.pat))) && !stop;
        if (stop)       ctl_d.run = 1'b0;
        else if (start) ctl_d.run = 1'b1;
        emit      = ctl_q.run && !stop && !restart;
        ins_hit   = err_insert && emit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{run: 1'b0, pat: PAT_P7};
        else        ctl_q <= ctl_d;
    end

    assign run_q = ctl_q.run;
    assign pat_q = ctl_q.pat;

    lbk_gen i_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .emit     (emit),
        .corrupt  (ins_hit),
        .pat      (ctl_q.pat),
        .tx_data  (tx_data),
        .tx_valid (tx_valid)
    );

    lbk_chk #(.LOSS_LIMIT(LOSS_LIMIT)) i_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .active   (ctl_q.run),
        .pat      (ctl_q.pat),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .locked   (locked),
        .err_hit  (err_hit)
    );

    lbk_count #(.CNT_W(CNT_W)) i_ins_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .inc   (ins_hit),
        .count (ins_count)
    );

    lbk_count #(.CNT_W(CNT_W)) i_det_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .inc   (err_hit),
        .count (det_count)
    );
endmodule

// File: rtl/lbk_props.sv
`timescale 1ns/1ps
module lbk_props
    import lbk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [2:0]       pat_q,
    input logic [2:0]       pat_sel,
    input logic             start,
    input logic             stop,
    input logic             clear,
    input logic             err_insert,
    input logic             locked,
    input logic             tx_valid,
    input logic [DW-1:0]    tx_data,
    input logic [CNT_W-1:0] ins_count,
    input logic [CNT_W-1:0] det_count
);
    // R2: toggle pattern words differ from the fixed word at most in bit 0
    p_hf_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && pat_q == PAT_HF) |-> (tx_data[DW-1:1] == HF_WORD[DW-1:1]));

    // R4: no word leaves while idle
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tx_valid);

    // R5: accepted insert request steps the inserted counter by one
    p_ins_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && err_insert && !stop && !start && pat_sel == pat_q && !clear)
        |=> (ins_count == $past(ins_count) + 1'b1));

    // R6: idle insert requests leave the counter alone
    p_ins_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(ins_count));

    // R8: nothing is counted while not aligned
    p_no_count_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !clear) |=> $stable(det_count));

    // R9: detected counter never jumps by more than one
    p_det_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (det_count == $past(det_count) || det_count == $past(det_count) + 1'b1));

    // R11: clear zeroes both counters
    p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ins_count == '0 && det_count == '0));

    // R12: pattern change while running drops alignment and emits nothing
    p_sel_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !stop && pat_sel != pat_q) |=> (!locked && !tx_valid));
endmodule

bind loopback_pattern_engine lbk_props #(.CNT_W(CNT_W)) i_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .pat_q      (pat_q),
    .pat_sel    (pat_sel),
    .start      (start),
    .stop       (stop),
    .clear      (clear),
    .err_insert (err_insert),
    .locked     (locked),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .ins_count  (ins_count),
    .det_count  (det_count)
);

// File: tb/test_loopback_pattern_engine.sv
`timescale 1ns/1ps
module test_loopback_pattern_engine;
    localparam int DW    = 32;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic [2:0] sel;
        logic [5:0] n;
        logic [5:0] k;
        logic [1:0] kind;   // 0 pseudo-random, 1 toggle, 2 square wave
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 6'd7,  6'd6,  2'd0},
        '{3'd1, 6'd15, 6'd14, 2'd0},
        '{3'd2, 6'd23, 6'd18, 2'd0},
        '{3'd3, 6'd31, 6'd28, 2'd0},
        '{3'd4, 6'd0,  6'd0,  2'd1},
        '{3'd5, 6'd0,  6'd0,  2'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       pat_sel = 3'd0;
    logic             start = 1'b0, stop = 1'b0, clear = 1'b0, err_insert = 1'b0;
    logic [DW-1:0]    tx_data, rx_data, rx_drive = '0;
    logic             tx_valid, rx_valid, rx_vdrive = 1'b0;
    logic             loop_en = 1'b1, rx_flip = 1'b0;
    logic             locked;
    logic [CNT_W-1:0] ins_count, det_count;
    int               n_chk = 0, n_fail = 0;
    bit               done = 1'b0;

    always #2.5 clk = ~clk;

    assign rx_data  = loop_en ? (tx_data ^ {{(DW-1){1'b0}}, rx_flip}) : rx_drive;
    assign rx_valid = loop_en ? tx_valid : rx_vdrive;

    loopback_pattern_engine #(.CNT_W(CNT_W), .LOSS_LIMIT(8)) i_loopback_pattern_engine (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .start(start), .stop(stop),
        .clear(clear), .err_insert(err_insert), .tx_data(tx_data), .tx_valid(tx_valid),
        .rx_data(rx_data), .rx_valid(rx_valid), .locked(locked),
        .ins_count(ins_count), .det_count(det_count)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask

    task automatic pulse_clear();
        clear = 1'b1; @(negedge clk); clear = 1'b0;
    endtask

    // Samples the transmit stream and counts pattern violations.
    task automatic watch(input vec_t v, input int cycles, output int bad, output bit first_valid);
        logic [63:0] hist;
        int          seen, runlen;
        logic        cur, b, e;
        hist = '0; seen = 0; runlen = 0; cur = 1'b1; bad = 0; first_valid = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (c == 0) first_valid = tx_valid;
            if (tx_valid) begin
                if (v.kind == 2'd1 && tx_data != 32'hAAAAAAAA) bad++;
                for (int i = DW - 1; i >= 0; i--) begin
                    b = tx_data[i];
                    if (v.kind == 2'd0) begin
                        if (seen >= int'(v.n)) begin
                            e = hist[v.n - 6'd1] ^ hist[v.k - 6'd1];
                            if (b != e) bad++;
                        end
                        hist = {hist[62:0], b};
                    end else if (v.kind == 2'd2) begin
                        if (seen == 0) begin
                            if (!b) bad++;
                            cur = b; runlen = 1;
                        end else if (b == cur) begin
                            runlen++;
                        end else begin
                            if (runlen != 33) bad++;
                            cur = b; runlen = 1;
                        end
                    end
                    seen++;
                end
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int  bad;
        bit  fv;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        check(locked == 1'b0 && tx_valid == 1'b0, "R13 flags", {locked, tx_valid}, 0);
        check(ins_count == 0 && det_count == 0, "R13 counters", {ins_count, det_count}, 0);

        // Vector table: each pattern in loopback
        for (int v = 0; v < 6; v++) begin
            pat_sel = VECS[v].sel;
            pulse_clear();
            pulse_start();
            check(tx_valid == 1'b0, "R4 no word on start edge", tx_valid, 0);
            watch(VECS[v], 60, bad, fv);
            check(fv == 1'b1, "R4 first word one edge later", fv, 1);
            tag = (VECS[v].kind == 2'd0) ? "R1 recurrence" : (VECS[v].kind == 2'd1) ? "R2 toggle word" : "R3 run length";
            check(bad == 0, tag, bad, 0);
            check(locked == 1'b1, "R7 locked in loopback", locked, 1);
            check(det_count == 0, "R9 clean data counts nothing", det_count, 0);
            err_insert = 1'b1;
            @(negedge clk);
            err_insert = 1'b0;
            check(ins_count == 1, "R5 inserted count", ins_count, 1);
            if (VECS[v].kind == 2'd1)
                check(tx_data == 32'hAAAAAAAB, "R5 bit0 inverted", tx_data, 64'hAAAAAAAB);
            check(det_count == 0, "R9 not yet received", det_count, 0);
            @(negedge clk);
            check(det_count == 1, "R9 detected one word", det_count, 1);
            @(negedge clk);
            check(locked == 1'b1 && det_count == 1, "R9 single error only", {locked, det_count}, {1'b1, 16'd1});
            pulse_stop();
            check(tx_valid == 1'b0, "R4 stream ends at stop", tx_valid, 0);
        end

        // R6: insert while stopped
        err_insert = 1'b1;
        @(negedge clk);
        err_insert = 1'b0;
        check(ins_count == 1 && tx_valid == 1'b0, "R6 idle insert ignored", {ins_count, tx_valid}, {16'd1, 1'b0});

        // R11: clear zeroes both
        pulse_clear();
        check(ins_count == 0 && det_count == 0, "R11 clear", {ins_count, det_count}, 0);

        // R10: loss of lock threshold
        pat_sel = 3'd0;
        pulse_start();
        repeat (10) @(negedge clk);
        rx_flip = 1'b1;
        repeat (7) @(negedge clk);
        rx_flip = 1'b0;
        check(locked == 1'b1, "R10 seven misses keep lock", locked, 1);
        check(det_count == 7, "R9 seven counted", det_count, 7);
        repeat (3) @(negedge clk);
        check(det_count == 7 && locked == 1'b1, "R10 clean after burst", {det_count, locked}, {16'd7, 1'b1});
        rx_flip = 1'b1;
        repeat (8) @(negedge clk);
        rx_flip = 1'b0;
        check(locked == 1'b0, "R10 eighth miss drops lock", locked, 0);
        check(det_count == 15, "R10 eight counted", det_count, 15);
        repeat (6) @(negedge clk);
        check(locked == 1'b1 && det_count == 15, "R10 relock", {locked, det_count}, {1'b1, 16'd15});

        // R12: pattern change while running
        pat_sel = 3'd2;
        @(negedge clk);
        check(locked == 1'b0 && tx_valid == 1'b0, "R12 restart on change", {locked, tx_valid}, 0);
        watch(VECS[2], 12, bad, fv);
        check(bad == 0, "R12 new pattern from fresh start", bad, 0);
        check(locked == 1'b1 && det_count == 15, "R12 relock new pattern", {locked, det_count}, {1'b1, 16'd15});
        pulse_stop();

        // R8: zero stream never locks, nothing counted
        loop_en   = 1'b0;
        rx_drive  = '0;
        rx_vdrive = 1'b1;
        pat_sel   = 3'd0;
        pulse_clear();
        pulse_start();
        repeat (20) @(negedge clk);
        check(locked == 1'b0, "R8 zero stream unlocked", locked, 0);
        check(det_count == 0, "R8 nothing counted", det_count, 0);
        pulse_stop();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule